// File: doc/BRIEF.md
# Nybble-Serial Bank Register Port

This block is the host-side receiver for bank-switching registers reached through ordinary memory writes over only four data lines. A memory write becomes a register access only while an active-low qualifier line, driven from a spare output port bit, is held low. The top three address bits pick one of four registers. Each 8-bit value reaches the block as two 4-bit writes, low half first. A steering flip-flop keeps track of which half is due next.

Completed bytes for the three data registers are handed to the downstream bank logic with a one-cycle valid pulse and a register identifier. The command register does not build bytes. Its nybbles are decoded as soon as they arrive and produce single-cycle command pulses. One of these commands re-aligns the steering, and it is recognised whether it comes alone, as a pair, or while the steering is out of step. Reads return a 4-bit status nybble taken from downstream state, which is not the data that was written.

Top module: `nib_reg_port`

## Requirements
- R1: While `qual_ni` is high, a write produces no byte and no command pulse, and it leaves the steering unchanged.
- R2: Register codes on `addr_i` (A15..A13) are 3'b010 (select register, id 0), 3'b100 (bank register, id 1), 3'b101 (assign register, id 2) and 3'b110 (command register). Writes to any other code have no effect.
- R3: On the data registers, the first accepted write supplies the low nybble and the second supplies the high nybble. The cycle after the second write, `byte_vld_o` pulses with `byte_o` = {high, low} and with `byte_id_o` set to the id of the second write.
- R4: After reset the steering expects a low nybble, every pulse output is 0 and `setup_o` is 0.
- R5: A command-register nybble of 4'h2, in either steering phase, pulses `resync_o` the next cycle, and the following accepted nybble is taken as a low nybble.
- R6: A command-register nybble of 4'h0 that directly follows a 4'h2 command nybble is absorbed. It produces no pulse and does not change the steering.
- R7: A command-register nybble written while a low nybble is due is decoded the next cycle: 4'h0 pulses `chain_rst_o` and sets `setup_o`; 4'h1 pulses `chain_step_o`; 4'h4 pulses `setup_end_o` and clears `setup_o`. The steering then expects a high nybble.
- R8: A command-register nybble written while a high nybble is due produces no pulse and returns the steering to low. A low-phase nybble other than 0, 1, 2 or 4 produces no pulse.
- R9: A read with `qual_ni` low on a register code raises `rd_hit_o` and returns on `rdata_o` the following nybble: select register gives `chunk_sel_i[3:0]`, bank register gives `chunk_sel_i[7:4]`, assign register gives `bank_stat_i[3:0]`, command register gives `bank_stat_i[7:4]`. Any other read gives `rd_hit_o` = 0.
- R10: Every output pulse lasts exactly one cycle, and at most one of `byte_vld_o`, `chain_rst_o`, `chain_step_o`, `setup_end_o` and `resync_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Memory write strobe, one cycle per write |
| rd_i | input | 1 | Memory read strobe |
| qual_ni | input | 1 | Register-access qualifier, active low |
| addr_i | input | 3 | Address bits A15..A13 |
| wdata_i | input | 4 | Data bits D3..D0 of the write |
| chunk_sel_i | input | 8 | Chunk-select byte of the accessed bank |
| bank_stat_i | input | 8 | Status byte of the accessed bank |
| rdata_o | output | 4 | Read nybble |
| rd_hit_o | output | 1 | Read is a register read |
| byte_vld_o | output | 1 | Assembled byte valid pulse |
| byte_id_o | output | 2 | Register id of the assembled byte |
| byte_o | output | 8 | Assembled byte |
| chain_rst_o | output | 1 | Reset-chain / enter-setup command pulse |
| chain_step_o | output | 1 | Step-chain command pulse |
| setup_end_o | output | 1 | End-setup command pulse |
| resync_o | output | 1 | Steering re-alignment pulse |
| setup_o | output | 1 | Setup mode flag |

## Verification
The bench goes after steering that is out of step. It writes a lone low nybble and then a re-align command, and expects the next pair to assemble correctly. A design that ignored the command in the high phase would swap the nybbles of every later byte. It sends the re-align command as a pair and checks that the trailing zero is absorbed; a design that decoded that zero would fire a spurious chain reset and drop into setup mode. It also writes with the qualifier high, writes to unused address codes and sends command nybbles in the high phase, and confirms that the byte assembled afterwards is intact. A design that let any of these move the steering would misassemble that byte.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SEL    = 3'b010;
  localparam logic [ADDR_W-1:0] A_BANK   = 3'b100;
  localparam logic [ADDR_W-1:0] A_ASSIGN = 3'b101;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'b110;

  typedef enum logic [1:0] {
    REG_SEL    = 2'd0,
    REG_BANK   = 2'd1,
    REG_ASSIGN = 2'd2,
    REG_CMD    = 2'd3
  } reg_id_e;

  localparam int CMD_CHAIN_RST = 0;
  localparam int CMD_STEP      = 1;
  localparam int CMD_RESYNC    = 2;
  localparam int CMD_SETUP_END = 4;
endpackage

// File: rtl/nrp_decode.sv
module nrp_decode
  import nrp_pkg::*;
(
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              qual_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              acc_wr_o,
  output logic              acc_rd_o,
  output reg_id_e           id_o
);
  logic hit;

  always_comb begin
    hit  = 1'b1;
    id_o = REG_SEL;
    unique case (addr_i)
      A_SEL:    id_o = REG_SEL;
      A_BANK:   id_o = REG_BANK;
      A_ASSIGN: id_o = REG_ASSIGN;
      A_CMD:    id_o = REG_CMD;
      default:  hit  = 1'b0;
    endcase
  end

  // qualifier low turns a memory cycle into a register cycle
  assign acc_wr_o = wr_i && !qual_ni && hit;
  assign acc_rd_o = rd_i && !qual_ni && hit;
endmodule

// File: rtl/nrp_steer.sv
module nrp_steer
  import nrp_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  reg_id_e            id_i,
  input  logic [NIB_W-1:0]   nib_i,
  output logic               byte_vld_o,
  output reg_id_e            byte_id_o,
  output logic [2*NIB_W-1:0] byte_o,
  output logic               cmd_vld_o,
  output logic [NIB_W-1:0]   cmd_nib_o,
  output logic               resync_o
);
  localparam logic [NIB_W-1:0] NIB_RESYNC = NIB_W'(CMD_RESYNC);

  logic             hi_q;    // high nybble due next
  logic             tail_q;  // previous command nybble was a resync
  logic [NIB_W-1:0] lo_q;

  logic is_cmd, is_sync, absorb;

  always_comb begin
    is_cmd  = (id_i == REG_CMD);
    is_sync = is_cmd && (nib_i == NIB_RESYNC);
    absorb  = is_cmd && tail_q && (nib_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q       <= 1'b0;
      tail_q     <= 1'b0;
      lo_q       <= '0;
      byte_vld_o <= 1'b0;
      byte_id_o  <= REG_SEL;
      byte_o     <= '0;
      cmd_vld_o  <= 1'b0;
      cmd_nib_o  <= '0;
      resync_o   <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      cmd_vld_o  <= 1'b0;
      resync_o   <= 1'b0;
      if (acc_i) begin
        if (is_sync) begin
          hi_q     <= 1'b0;
          tail_q   <= 1'b1;
          resync_o <= 1'b1;
        end else if (absorb) begin
          // high half of a two-nybble resync
          tail_q <= 1'b0;
        end else if (is_cmd) begin
          tail_q <= 1'b0;
          if (!hi_q) begin
            cmd_vld_o <= 1'b1;
            cmd_nib_o <= nib_i;
            hi_q      <= 1'b1;
          end else begin
            hi_q <= 1'b0;
          end
        end else begin
          tail_q <= 1'b0;
          if (!hi_q) begin
            lo_q <= nib_i;
            hi_q <= 1'b1;
          end else begin
            byte_vld_o <= 1'b1;
            byte_id_o  <= id_i;
            byte_o     <= {nib_i, lo_q};
            hi_q       <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/nrp_cmd.sv
module nrp_cmd
  import nrp_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_vld_i,
  input  logic [NIB_W-1:0] cmd_nib_i,
  output logic             chain_rst_o,
  output logic             chain_step_o,
  output logic             setup_end_o,
  output logic             setup_o
);
  always_comb begin
    chain_rst_o  = 1'b0;
    chain_step_o = 1'b0;
    setup_end_o  = 1'b0;
    if (cmd_vld_i) begin
      unique case (cmd_nib_i)
        NIB_W'(CMD_CHAIN_RST): chain_rst_o  = 1'b1;
        NIB_W'(CMD_STEP):      chain_step_o = 1'b1;
        NIB_W'(CMD_SETUP_END): setup_end_o  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          setup_o <= 1'b0;
    else if (chain_rst_o) setup_o <= 1'b1;
    else if (setup_end_o) setup_o <= 1'b0;
  end
endmodule

// File: rtl/nrp_rdmux.sv
module nrp_rdmux
  import nrp_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               acc_rd_i,
  input  reg_id_e            id_i,
  input  logic [2*NIB_W-1:0] chunk_sel_i,
  input  logic [2*NIB_W-1:0] bank_stat_i,
  output logic [NIB_W-1:0]   rdata_o,
  output logic               rd_hit_o
);
  always_comb begin
    rdata_o  = '0;
    rd_hit_o = acc_rd_i;
    if (acc_rd_i) begin
      unique case (id_i)
        REG_SEL:    rdata_o = chunk_sel_i[NIB_W-1:0];
        REG_BANK:   rdata_o = chunk_sel_i[2*NIB_W-1:NIB_W];
        REG_ASSIGN: rdata_o = bank_stat_i[NIB_W-1:0];
        REG_CMD:    rdata_o = bank_stat_i[2*NIB_W-1:NIB_W];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nib_reg_port.sv
module nib_reg_port
  import nrp_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic               qual_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NIB_W-1:0]   wdata_i,
  input  logic [2*NIB_W-1:0] chunk_sel_i,
  input  logic [2*NIB_W-1:0] bank_stat_i,
  output logic [NIB_W-1:0]   rdata_o,
  output logic               rd_hit_o,
  output logic               byte_vld_o,
  output logic [1:0]         byte_id_o,
  output logic [2*NIB_W-1:0] byte_o,
  output logic               chain_rst_o,
  output logic               chain_step_o,
  output logic               setup_end_o,
  output logic               resync_o,
  output logic               setup_o
);
  logic             acc_wr, acc_rd;
  reg_id_e          id, byte_id;
  logic             cmd_vld;
  logic [NIB_W-1:0] cmd_nib;

  nrp_decode u_decode (
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .qual_ni  (qual_ni),
    .addr_i   (addr_i),
    .acc_wr_o (acc_wr),
    .acc_rd_o (acc_rd),
    .id_o     (id)
  );

  nrp_steer #(.NIB_W(NIB_W)) u_steer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc_wr),
    .id_i       (id),
    .nib_i      (wdata_i),
    .byte_vld_o (byte_vld_o),
    .byte_id_o  (byte_id),
    .byte_o     (byte_o),
    .cmd_vld_o  (cmd_vld),
    .cmd_nib_o  (cmd_nib),
    .resync_o   (resync_o)
  );

  assign byte_id_o = byte_id;

  nrp_cmd #(.NIB_W(NIB_W)) u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_vld_i    (cmd_vld),
    .cmd_nib_i    (cmd_nib),
    .chain_rst_o  (chain_rst_o),
    .chain_step_o (chain_step_o),
    .setup_end_o  (setup_end_o),
    .setup_o      (setup_o)
  );

  nrp_rdmux #(.NIB_W(NIB_W)) u_rdmux (
    .acc_rd_i    (acc_rd),
    .id_i        (id),
    .chunk_sel_i (chunk_sel_i),
    .bank_stat_i (bank_stat_i),
    .rdata_o     (rdata_o),
    .rd_hit_o    (rd_hit_o)
  );
endmodule

// File: rtl/nrp_port_chk.sv
module nrp_port_chk
  import nrp_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic              qual_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NIB_W-1:0]  wdata_i,
  input logic              rd_hit_o,
  input logic              byte_vld_o,
  input logic              chain_rst_o,
  input logic              chain_step_o,
  input logic              setup_end_o,
  input logic              resync_o,
  input logic              setup_o
);
  logic any_out, is_reg;
  assign any_out = byte_vld_o | chain_rst_o | chain_step_o | setup_end_o | resync_o;
  assign is_reg  = (addr_i == A_SEL) || (addr_i == A_BANK) ||
                   (addr_i == A_ASSIGN) || (addr_i == A_CMD);

  // R1
  qual_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && qual_ni) |=> !any_out);

  // R2
  unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !qual_ni && !is_reg) |=> !any_out);

  // R3
  byte_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  // R5
  resync_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !qual_ni && addr_i == A_CMD && wdata_i == NIB_W'(CMD_RESYNC)) |=> resync_o);

  // R7
  setup_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_rst_o |=> setup_o);

  // R7
  setup_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_end_o |=> !setup_o);

  // R9
  rd_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_o |-> (rd_i && !qual_ni && is_reg));

  // R10
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_vld_o, chain_rst_o, chain_step_o, setup_end_o, resync_o}));
endmodule

bind nib_reg_port nrp_port_chk #(.NIB_W(NIB_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .qual_ni      (qual_ni),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rd_hit_o     (rd_hit_o),
  .byte_vld_o   (byte_vld_o),
  .chain_rst_o  (chain_rst_o),
  .chain_step_o (chain_step_o),
  .setup_end_o  (setup_end_o),
  .resync_o     (resync_o),
  .setup_o      (setup_o)
);

// File: tb/nib_reg_port_test.sv
module nib_reg_port_test;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, qual_ni = 1'b1;
  logic [2:0] addr_i = '0;
  logic [3:0] wdata_i = '0;
  logic [7:0] chunk_sel_i = '0, bank_stat_i = '0;
  logic [3:0] rdata_o;
  logic       rd_hit_o, byte_vld_o;
  logic [1:0] byte_id_o;
  logic [7:0] byte_o;
  logic       chain_rst_o, chain_step_o, setup_end_o, resync_o, setup_o;

  nib_reg_port uut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  typedef struct {
    logic       bv;
    logic [1:0] id;
    logic [7:0] b;
    logic [3:0] cmd;  // {resync, setup_end, step, chain_rst}
    string      req;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  logic done = 1'b0;

  // reference state derived from the requirements
  logic       m_hi = 1'b0, m_tail = 1'b0, m_setup = 1'b0;
  logic [3:0] m_lo = '0;

  task automatic wr(input logic qn, input logic [2:0] a, input logic [3:0] n, input string req);
    exp_t e;
    e.bv = 1'b0; e.id = 2'd0; e.b = 8'h00; e.cmd = 4'b0000; e.req = req;
    if (!qn && (a == 3'b010 || a == 3'b100 || a == 3'b101 || a == 3'b110)) begin
      if (a == 3'b110) begin
        if (n == 4'h2) begin
          e.cmd = 4'b1000; m_hi = 1'b0; m_tail = 1'b1;
        end else if (m_tail && n == 4'h0) begin
          m_tail = 1'b0;
        end else begin
          m_tail = 1'b0;
          if (!m_hi) begin
            m_hi = 1'b1;
            case (n)
              4'h0: begin e.cmd = 4'b0001; m_setup = 1'b1; end
              4'h1: e.cmd = 4'b0010;
              4'h4: begin e.cmd = 4'b0100; m_setup = 1'b0; end
              default: ;
            endcase
          end else m_hi = 1'b0;
        end
      end else begin
        m_tail = 1'b0;
        if (!m_hi) begin
          m_lo = n; m_hi = 1'b1;
        end else begin
          e.bv = 1'b1; e.b = {n, m_lo}; m_hi = 1'b0;
          e.id = (a == 3'b010) ? 2'd0 : (a == 3'b100) ? 2'd1 : 2'd2;
        end
      end
    end
    q.push_back(e);
    @(negedge clk_i);
    wr_i = 1'b1; qual_ni = qn; addr_i = a; wdata_i = n;
    @(negedge clk_i);
    wr_i = 1'b0; qual_ni = 1'b1;
  endtask

  // monitor: pops one expected item per accepted write, checks idle cycles too
  initial begin
    logic took;
    exp_t e;
    logic [14:0] got, want;
    forever begin
      @(posedge clk_i);
      took = wr_i && rst_ni;
      #1;
      if (!rst_ni || done) continue;
      e.bv = 1'b0; e.id = 2'd0; e.b = 8'h00; e.cmd = 4'b0000; e.req = "R10";
      if (took && q.size() > 0) e = q.pop_front();
      got  = {byte_vld_o, byte_vld_o ? byte_id_o : 2'd0, byte_vld_o ? byte_o : 8'h00,
              resync_o, setup_end_o, chain_step_o, chain_rst_o};
      want = {e.bv, e.id, e.b, e.cmd};
      compared++;
      if (got !== want) begin
        mismatched++;
        $display("FAIL %s: got %h expected %h", e.req, got, want);
      end
    end
  end

  task automatic chk_setup(input string req);
    @(negedge clk_i);
    compared++;
    if (setup_o !== m_setup) begin
      mismatched++;
      $display("FAIL %s: setup_o got %b expected %b", req, setup_o, m_setup);
    end
  endtask

  task automatic rd(input logic qn, input logic [2:0] a, input logic hit, input logic [3:0] d,
                    input string req);
    @(negedge clk_i);
    rd_i = 1'b1; qual_ni = qn; addr_i = a;
    #1;
    compared++;
    if (rd_hit_o !== hit || (hit && rdata_o !== d)) begin
      mismatched++;
      $display("FAIL %s: read hit/data got %b/%h expected %b/%h", req, rd_hit_o, rdata_o, hit, d);
    end
    @(negedge clk_i);
    rd_i = 1'b0; qual_ni = 1'b1;
  endtask

  initial begin
    #(CLK_P * 20000);
    mismatched++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R4: reset state
    compared++;
    if ({byte_vld_o, chain_rst_o, chain_step_o, setup_end_o, resync_o, setup_o} !== 6'b0) begin
      mismatched++;
      $display("FAIL R4: outputs got %b expected 000000",
               {byte_vld_o, chain_rst_o, chain_step_o, setup_end_o, resync_o, setup_o});
    end
    // R4/R3: first write after reset is a low nybble
    wr(1'b0, 3'b010, 4'h5, "R4");
    wr(1'b0, 3'b010, 4'hA, "R3");
    wr(1'b0, 3'b100, 4'h3, "R3");
    wr(1'b0, 3'b100, 4'hC, "R3");
    wr(1'b0, 3'b101, 4'hF, "R3");
    wr(1'b0, 3'b101, 4'h0, "R3");
    // R1: qualifier high is plain memory
    wr(1'b1, 3'b010, 4'h7, "R1");
    wr(1'b1, 3'b110, 4'h0, "R1");
    wr(1'b0, 3'b010, 4'h1, "R1");
    wr(1'b0, 3'b010, 4'h2, "R1");
    // R2: unmapped address codes
    wr(1'b0, 3'b000, 4'h9, "R2");
    wr(1'b0, 3'b001, 4'h9, "R2");
    wr(1'b0, 3'b011, 4'h9, "R2");
    wr(1'b0, 3'b111, 4'h9, "R2");
    wr(1'b0, 3'b100, 4'hE, "R2");
    wr(1'b0, 3'b100, 4'h6, "R2");
    // R7: commands
    wr(1'b0, 3'b110, 4'h0, "R7");
    wr(1'b0, 3'b110, 4'h0, "R7");
    chk_setup("R7");
    wr(1'b0, 3'b110, 4'h1, "R7");
    wr(1'b0, 3'b110, 4'h0, "R7");
    wr(1'b0, 3'b110, 4'h4, "R7");
    wr(1'b0, 3'b110, 4'h0, "R7");
    chk_setup("R7");
    // R5: resync with steering out of step
    wr(1'b0, 3'b010, 4'h6, "R5");
    wr(1'b0, 3'b110, 4'h2, "R5");
    wr(1'b0, 3'b010, 4'h9, "R5");
    wr(1'b0, 3'b010, 4'h8, "R5");
    // R6: resync as two nybbles
    wr(1'b0, 3'b110, 4'h2, "R6");
    wr(1'b0, 3'b110, 4'h0, "R6");
    wr(1'b0, 3'b100, 4'h1, "R6");
    wr(1'b0, 3'b100, 4'h2, "R6");
    chk_setup("R6");
    // R6: resync, absorbed zero, then a real chain reset
    wr(1'b0, 3'b110, 4'h2, "R6");
    wr(1'b0, 3'b110, 4'h0, "R6");
    wr(1'b0, 3'b110, 4'h0, "R6");
    wr(1'b0, 3'b110, 4'h0, "R6");
    chk_setup("R6");
    // R8: unknown values and high-phase command nybbles
    wr(1'b0, 3'b110, 4'h7, "R8");
    wr(1'b0, 3'b110, 4'h0, "R8");
    wr(1'b0, 3'b110, 4'h8, "R8");
    wr(1'b0, 3'b110, 4'h1, "R8");
    wr(1'b0, 3'b010, 4'h4, "R8");
    wr(1'b0, 3'b110, 4'h4, "R8");
    wr(1'b0, 3'b101, 4'hB, "R8");
    wr(1'b0, 3'b101, 4'hD, "R8");
    chk_setup("R8");
    // R5: resync in low phase, back-to-back resyncs
    wr(1'b0, 3'b110, 4'h2, "R5");
    wr(1'b0, 3'b110, 4'h2, "R5");
    wr(1'b0, 3'b110, 4'h4, "R5");
    wr(1'b0, 3'b110, 4'h0, "R5");
    chk_setup("R5");
    // R9: reads
    chunk_sel_i = 8'h5A;
    bank_stat_i = 8'hC3;
    rd(1'b0, 3'b010, 1'b1, 4'hA, "R9");
    rd(1'b0, 3'b100, 1'b1, 4'h5, "R9");
    rd(1'b0, 3'b101, 1'b1, 4'h3, "R9");
    rd(1'b0, 3'b110, 1'b1, 4'hC, "R9");
    rd(1'b1, 3'b010, 1'b0, 4'h0, "R9");
    rd(1'b0, 3'b000, 1'b0, 4'h0, "R9");
    repeat (4) @(negedge clk_i);
    compared++;
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL R10: pending items got %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule